// File: doc/BRIEF.md
# Slow-Tick Synchronized Register Writer

This block sits in front of a set of timekeeping registers that may only change on a slow timekeeping tick. A bus master writes a time value, an alarm value, an interrupt-control word or a prescaler switch through a small register bus. The block accepts the write into one shadow register and raises a pending flag. It moves the value into the visible, committed register on the next commit tick. While a write is pending, any further write to a tick-synchronized register is dropped without any error indication.

The commit tick comes from the committed prescaler switch. When the switch is on, the slow strobe (one pulse per second) paces the commits. When it is off, the fast strobe (the raw oscillator rate) paces them. A status register is not tick-synchronized. A write to it clears its sticky write-done flag in the same cycle, and that flag can raise the interrupt line when its enable bit is set in the committed interrupt-control word.

The whole block runs on one clock. The two ticks arrive as single-cycle strobes, so no clock-domain synchronizers are involved.

Top module: `syncTickWriter`

## Requirements
- R1: After reset, no write is pending, the write-done flag is clear, every register reads as zero and `irqOut` is low.
- R2: A write to address 0 (time), 1 (alarm), 2 (interrupt control) or 3 (prescaler) while nothing is pending is accepted. From the next cycle, status bit 14 (pending) reads 1 and the target address still reads its old committed value.
- R3: A pending write is committed at the first clock edge that comes after the accepting edge and has the selected tick high. From then on the target reads the new value (interrupt control keeps bits 15:0, prescaler keeps bit 0), status bit 14 reads 0 and status bit 15 (write done) reads 1.
- R4: A write to addresses 0 to 3 that arrives while a write is pending is dropped, and the value that is committed is the first one.
- R5: A write to address 4 (status) takes effect at once. A 1 in data bit 15 clears write-done, and a 0 leaves it unchanged. A status write never sets pending.
- R6: When committed prescaler bit 0 is 1, only `slowTick` commits. When it is 0, which is the state after reset, only `fastTick` commits.
- R7: `irqOut` is high exactly while write-done is set and committed interrupt-control bit 15 is 1.
- R8: When a commit and a status clear fall on the same edge, write-done ends up set.
- R9: When a disable of interrupt control is followed at once by an enable, before a tick, the enable is lost and the disable value is committed.
- R10: A write to an unmapped address (5 to 7) changes nothing and sets no pending flag. Such an address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | 3 | Register address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| slowTick | input | 1 | Slow commit strobe (prescaler on) |
| fastTick | input | 1 | Fast commit strobe (prescaler off) |
| irqOut | output | 1 | Write-done interrupt |

## Verification
The main function is driven in several patterns:
- A single write followed by a tick separates the shadow value from the committed value.
- Two back-to-back writes before a tick separate keep-first from keep-last behaviour.
- A disable followed at once by an enable reproduces the lost-enable hazard.

Ticks on the wrong strobe, given before and after the prescaler is switched on, show which tick source is in effect. A commit that coincides with a status clear shows which of the two wins. Writes to status and to unmapped addresses show that neither path disturbs the pending state.

// File: rtl/syncWrPkg.sv
package syncWrPkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int NUM_SYNC = 4;
  localparam int SEL_W    = $clog2(NUM_SYNC);

  localparam logic [ADDR_W-1:0] ADR_TIME  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_ALARM = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_ICTL  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PRESC = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd4;

  localparam int STAT_DONE_BIT = 15;
  localparam int STAT_PEND_BIT = 14;
  localparam int ICTL_W        = 16;
  localparam int ICTL_DONE_EN  = 15;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic             commit;
    logic [SEL_W-1:0] target;
  } wrStrobeT;

  // keep mask of each committed register
  function automatic logic [DATA_W-1:0] keepMask(input int idx);
    logic [DATA_W-1:0] m;
    case (idx)
      int'(ADR_ICTL):  m = DATA_W'({ICTL_W{1'b1}});
      int'(ADR_PRESC): m = DATA_W'(1);
      default:         m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/syncWrCtrl.sv
module syncWrCtrl
  import syncWrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              clrDoneReq,
  input  logic              slowTick,
  input  logic              fastTick,
  input  logic              prescOn,
  output wrStrobeT          strb,
  output logic              pendingQ,
  output logic              completeQ
);
  logic isSynced, wrAccept, tickNow, commitNow, statClr;

  assign isSynced  = busAddr < ADDR_W'(NUM_SYNC);
  assign wrAccept  = busWe && isSynced && !pendingQ;
  assign tickNow   = prescOn ? slowTick : fastTick;
  assign commitNow = pendingQ && tickNow;
  assign statClr   = busWe && (busAddr == ADR_STAT) && clrDoneReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
    end else if (commitNow) begin
      pendingQ <= 1'b0;
    end else if (wrAccept) begin
      pendingQ <= 1'b1;
    end
  end

  // a commit wins over a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      completeQ <= 1'b0;
    end else if (commitNow) begin
      completeQ <= 1'b1;
    end else if (statClr) begin
      completeQ <= 1'b0;
    end
  end

  always_comb begin
    strb.capture = wrAccept;
    strb.commit  = commitNow;
    strb.target  = busAddr[SEL_W-1:0];
  end
endmodule

// File: rtl/syncWrData.sv
module syncWrData
  import syncWrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobeT          strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              pendingQ,
  input  logic              completeQ,
  output logic [DATA_W-1:0] busRdata,
  output logic              prescOn,
  output logic              doneIrqEn
);
  logic [DATA_W-1:0] shadowQ;
  logic [SEL_W-1:0]  shadowSelQ;
  logic [DATA_W-1:0] liveQ [NUM_SYNC];
  logic [DATA_W-1:0] statWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ    <= '0;
      shadowSelQ <= '0;
    end else if (strb.capture) begin
      shadowQ    <= busWdata;
      shadowSelQ <= strb.target;
    end
  end

  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_live
    always_ff @(posedge clk) begin
      if (!rstN) begin
        liveQ[i] <= '0;
      end else if (strb.commit && (shadowSelQ == SEL_W'(i))) begin
        liveQ[i] <= shadowQ & keepMask(i);
      end
    end
  end

  always_comb begin
    statWord                = '0;
    statWord[STAT_DONE_BIT] = completeQ;
    statWord[STAT_PEND_BIT] = pendingQ;
  end

  always_comb begin
    if (busAddr < ADDR_W'(NUM_SYNC)) begin
      busRdata = liveQ[busAddr[SEL_W-1:0]];
    end else if (busAddr == ADR_STAT) begin
      busRdata = statWord;
    end else begin
      busRdata = '0;
    end
  end

  assign prescOn   = liveQ[ADR_PRESC[SEL_W-1:0]][0];
  assign doneIrqEn = liveQ[ADR_ICTL[SEL_W-1:0]][ICTL_DONE_EN];
endmodule

// File: rtl/syncTickWriter.sv
module syncTickWriter
  import syncWrPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              slowTick,
  input  logic              fastTick,
  output logic              irqOut
);
  wrStrobeT strb;
  logic pendingQ, completeQ, prescOn, doneIrqEn;

  syncWrCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .clrDoneReq (busWdata[STAT_DONE_BIT]),
    .slowTick   (slowTick),
    .fastTick   (fastTick),
    .prescOn    (prescOn),
    .strb       (strb),
    .pendingQ   (pendingQ),
    .completeQ  (completeQ)
  );

  syncWrData data_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .busAddr   (busAddr),
    .pendingQ  (pendingQ),
    .completeQ (completeQ),
    .busRdata  (busRdata),
    .prescOn   (prescOn),
    .doneIrqEn (doneIrqEn)
  );

  assign irqOut = completeQ && doneIrqEn;
endmodule

// File: rtl/syncTickWriterChk.sv
module syncTickWriterChk
  import syncWrPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              clrBit,
  input logic              slowTick,
  input logic              fastTick,
  input logic              irqOut,
  input logic              pendingQ,
  input logic              completeQ,
  input logic              prescOn
);
  logic tickSel;
  assign tickSel = prescOn ? slowTick : fastTick;

  // R2
  accept_sets_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe && (busAddr < ADDR_W'(NUM_SYNC)) && !pendingQ |=> pendingQ);

  // R3
  commit_sets_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ && tickSel |=> !pendingQ && completeQ);

  // R6
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendingQ && !tickSel |=> pendingQ);

  // R5
  status_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe && (busAddr == ADR_STAT) && clrBit && !(pendingQ && tickSel) |=> !completeQ);

  // R7
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !completeQ |-> !irqOut);

  // R10
  unmapped_no_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWe && (busAddr > ADR_STAT) && !pendingQ |=> !pendingQ);
endmodule

bind syncTickWriter syncTickWriterChk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busWe     (busWe),
  .busAddr   (busAddr),
  .clrBit    (busWdata[15]),
  .slowTick  (slowTick),
  .fastTick  (fastTick),
  .irqOut    (irqOut),
  .pendingQ  (pendingQ),
  .completeQ (completeQ),
  .prescOn   (prescOn)
);

// File: tb/syncTickWriter_tb_top.sv
module syncTickWriter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        slowTick = 1'b0;
  logic        fastTick = 1'b0;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // scoreboard: expected value, irq-or-read kind, requirement tag
  logic [31:0] expQ [$];
  bit          kindQ [$];
  string       tagQ [$];

  always #5 clk = ~clk;

  syncTickWriter dut_i (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .slowTick(slowTick), .fastTick(fastTick), .irqOut(irqOut)
  );

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        logic [31:0] e;
        logic [31:0] act;
        bit k;
        string t;
        e = expQ.pop_front();
        k = kindQ.pop_front();
        t = tagQ.pop_front();
        act = k ? {31'd0, irqOut} : busRdata;
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s: %s actual=%h expected=%h", t, k ? "irq" : "read", act, e);
        end
      end
    end
  end

  task automatic expRead(input logic [2:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    busAddr = a;
    expQ.push_back(e); kindQ.push_back(1'b0); tagQ.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic expIrq(input bit e, input string t);
    @(posedge clk); #1;
    expQ.push_back({31'd0, e}); kindQ.push_back(1'b1); tagQ.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic pulse(input bit slow);
    @(posedge clk); #1;
    if (slow) slowTick = 1'b1; else fastTick = 1'b1;
    @(posedge clk); #1;
    slowTick = 1'b0; fastTick = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) expRead(3'(a), 32'h0, "R1");
    expIrq(1'b0, "R1");

    // R2 accept: pending visible, old value retained
    doWrite(3'd0, 32'h0001_2345);
    expRead(3'd4, 32'h0000_4000, "R2");
    expRead(3'd0, 32'h0, "R2");
    // R6 slow tick ignored while prescaler off
    pulse(1'b1);
    expRead(3'd0, 32'h0, "R6");
    // R3 commit on fast tick
    pulse(1'b0);
    expRead(3'd0, 32'h0001_2345, "R3");
    expRead(3'd4, 32'h0000_8000, "R3");

    // R5 status clear semantics
    doWrite(3'd4, 32'h0000_7FFF);
    expRead(3'd4, 32'h0000_8000, "R5");
    doWrite(3'd4, 32'h0000_8000);
    expRead(3'd4, 32'h0000_0000, "R5");

    // R4 second write dropped
    doWrite(3'd1, 32'h0000_AAAA);
    doWrite(3'd1, 32'h0000_BBBB);
    pulse(1'b0);
    expRead(3'd1, 32'h0000_AAAA, "R4");
    expRead(3'd4, 32'h0000_8000, "R4");

    // R7 interrupt enable
    doWrite(3'd2, 32'hFFFF_8000);
    pulse(1'b0);
    expRead(3'd2, 32'h0000_8000, "R3");
    expIrq(1'b1, "R7");
    doWrite(3'd4, 32'h0000_8000);
    expIrq(1'b0, "R7");

    // R9 disable then immediate enable: enable lost
    doWrite(3'd2, 32'h0000_0000);
    doWrite(3'd2, 32'h0000_8004);
    pulse(1'b0);
    expRead(3'd2, 32'h0000_0000, "R9");
    expIrq(1'b0, "R9");

    // R6 prescaler on: fast ticks no longer commit
    doWrite(3'd3, 32'hFFFF_FFFF);
    pulse(1'b0);
    expRead(3'd3, 32'h0000_0001, "R6");
    doWrite(3'd4, 32'h0000_8000);
    doWrite(3'd0, 32'h0000_0077);
    pulse(1'b0);
    expRead(3'd0, 32'h0001_2345, "R6");
    expRead(3'd4, 32'h0000_4000, "R6");
    pulse(1'b1);
    expRead(3'd0, 32'h0000_0077, "R6");

    // R8 commit and clear on the same edge
    doWrite(3'd0, 32'h0000_0099);
    @(posedge clk); #1;
    busWe = 1'b1; busAddr = 3'd4; busWdata = 32'h0000_8000; slowTick = 1'b1;
    @(posedge clk); #1;
    busWe = 1'b0; slowTick = 1'b0;
    expRead(3'd4, 32'h0000_8000, "R8");
    expRead(3'd0, 32'h0000_0099, "R8");

    // R10 unmapped write ignored
    doWrite(3'd4, 32'h0000_8000);
    doWrite(3'd6, 32'h0000_0005);
    expRead(3'd4, 32'h0000_0000, "R10");
    expRead(3'd6, 32'h0000_0000, "R10");
    pulse(1'b1);
    expRead(3'd0, 32'h0000_0099, "R10");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule